// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the configuration front end of an I/O controller. It is reached through two byte-wide I/O addresses: an index port that names a register and a data port that reads or writes it. Configuration space stays closed after reset. It opens only when a fixed four-byte unlock key has been written to the index port. It closes again when software writes a specific exit command.

Once open, a small set of global registers is always visible. These are a logical-device selector, a 16-bit chip identifier and a revision nibble. Indices from 0x30 upward are banked: the selector picks which logical device answers there. Each device bank holds an activate bit and a 16-bit base address. Both are driven out of the block as plain outputs for the device logic behind it.

The host bus is modelled as single-cycle strobes. Writes take effect at the clock edge. Read data is combinational from the current register state.

Top module: `cfg_unlock_port`

## Requirements
- R1: After reset the port is closed (`cfg_open`=0), the logical device number is 0, and every activate bit and base address is 0.
- R2: Writing the bytes 0x87, 0x01, 0x55, 0x55 in that order to the index port (address 0x002E) opens the port; `cfg_open` is 1 from the clock edge of the fourth write onward.
- R3: An index-port byte that does not match the next expected key byte restarts matching. That breaking byte is itself judged as a first key byte, so 0x87, 0x87, 0x01, 0x55, 0x55 opens the port, while 0x87, 0x01, 0x55, 0x00, 0x55 leaves it closed.
- R4: While closed, reads of either port return 0xFF and data-port writes change no register or output.
- R5: While open, an index-port write selects the register index, and an index-port read returns that index.
- R6: Index 0x07 holds the logical device number. For indices 0x30 and above, the data port reaches bank N when the number is N < NUM_DEV. With a number of NUM_DEV or more, banked reads return 0xFF and banked writes are ignored.
- R7: Index 0x20 reads the chip identifier high byte, 0x21 the low byte, and 0x22 reads {4'b0, revision}; these answer whatever the logical device number is.
- R8: Bank index 0x30 bit 0 is the activate bit; it reads back as {7'b0, bit} and drives `dev_active[N]`.
- R9: Bank indices 0x60 (high byte) and 0x61 (low byte) hold the base address, driven on `dev_base[16*N +: 16]`.
- R10: Writing 0x02 to the data port while index 0x02 is selected closes the port from that clock edge on and clears the index; any other value written there has no effect.
- R11: A read and a write in the same cycle return the state from before the write, including the last cycle before the exit command closes the port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high; 0 otherwise |
| cfg_open | output | 1 | Configuration space is unlocked |
| dev_active | output | NUM_DEV | Activate bit of each device bank |
| dev_base | output | 16*NUM_DEV | Base address of each device bank, bank 0 in the low bits |

## Verification
Two functions can meet in one cycle: a data-port read and a data-port write. The most delicate pairing is a read issued in the same cycle as the exit command, or as a write to the logical-device register. The bench raises both strobes together at the data port. In that cycle it expects the pre-write value: 0x00 from index 0x02 rather than the closed-port 0xFF, and the old device number rather than the new one. One edge later it expects the closed behaviour or the new value.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  // register indices of the configuration space
  localparam logic [7:0] IDX_EXIT       = 8'h02;
  localparam logic [7:0] IDX_LDN        = 8'h07;
  localparam logic [7:0] IDX_ID_HI      = 8'h20;
  localparam logic [7:0] IDX_ID_LO      = 8'h21;
  localparam logic [7:0] IDX_REV        = 8'h22;
  localparam logic [7:0] IDX_BANK_FIRST = 8'h30;
  localparam logic [7:0] IDX_ACT        = 8'h30;
  localparam logic [7:0] IDX_BASE_HI    = 8'h60;
  localparam logic [7:0] IDX_BASE_LO    = 8'h61;
  localparam logic [7:0] EXIT_CODE      = 8'h02;
  localparam logic [7:0] CLOSED_READ    = 8'hFF;

  typedef logic [1:0] key_pos_t;

  typedef struct packed {
    logic     done;
    key_pos_t pos;
  } key_step_t;

  // byte expected at each position of the unlock key
  function automatic logic [7:0] key_byte(key_pos_t p);
    case (p)
      2'd0:    return 8'h87;
      2'd1:    return 8'h01;
      default: return 8'h55;
    endcase
  endfunction

  // one step of key matching; a breaking byte is re-judged as a first byte
  function automatic key_step_t key_step(key_pos_t p, logic [7:0] b);
    key_step_t r;
    r = '0;
    if (b == key_byte(p)) begin
      if (p == 2'd3) r.done = 1'b1;
      else           r.pos  = p + 2'd1;
    end else if (b == key_byte(2'd0)) begin
      r.pos = 2'd1;
    end
    return r;
  endfunction

  function automatic logic is_banked(logic [7:0] idx);
    return idx >= IDX_BANK_FIRST;
  endfunction

  // global register read, independent of the selected bank
  function automatic logic [7:0] global_read(logic [7:0] idx, logic [7:0] ldn,
                                             logic [15:0] id, logic [3:0] rev);
    case (idx)
      IDX_LDN:   return ldn;
      IDX_ID_HI: return id[15:8];
      IDX_ID_LO: return id[7:0];
      IDX_REV:   return {4'h0, rev};
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bank_read(logic [7:0] idx, logic act, logic [15:0] base);
    case (idx)
      IDX_ACT:     return {7'b0, act};
      IDX_BASE_HI: return base[15:8];
      IDX_BASE_LO: return base[7:0];
      default:     return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgp_key_seq.sv
module cfgp_key_seq
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr_i,
  input  logic [7:0] wbyte_i,
  input  logic       exit_i,
  output logic       open_o
);

  key_pos_t  pos_q;
  key_step_t step;
  logic      key_done;

  assign step     = key_step(pos_q, wbyte_i);
  assign key_done = !open_o && idx_wr_i && step.done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      pos_q  <= '0;
    end else if (open_o) begin
      if (exit_i) begin
        open_o <= 1'b0;
        pos_q  <= '0;
      end
    end else if (idx_wr_i) begin
      pos_q <= step.pos;
      if (step.done) open_o <= 1'b1;
    end
  end

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    key_done |=> open_o); // R2
  AST_NO_OPEN_WITHOUT_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_o && !key_done) |=> !open_o); // R3
  AST_EXIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && exit_i) |=> (!open_o && pos_q == 2'd0)); // R10
  AST_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && !exit_i) |=> open_o); // R5

endmodule

// File: rtl/cfgp_dev_bank.sv
module cfgp_dev_bank
  import cfgp_pkg::*;
#(
  parameter int BASE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [7:0]        idx_i,
  input  logic [7:0]        wdata_i,
  output logic              active_o,
  output logic [BASE_W-1:0] base_o,
  output logic [7:0]        rdata_o
);

  logic act_wr, hi_wr, lo_wr;

  assign act_wr = wr_i && idx_i == IDX_ACT;
  assign hi_wr  = wr_i && idx_i == IDX_BASE_HI;
  assign lo_wr  = wr_i && idx_i == IDX_BASE_LO;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      base_o   <= '0;
    end else begin
      if (act_wr) active_o       <= wdata_i[0];
      if (hi_wr)  base_o[15:8]   <= wdata_i;
      if (lo_wr)  base_o[7:0]    <= wdata_i;
    end
  end

  assign rdata_o = bank_read(idx_i, active_o, base_o);

  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(active_o) && $stable(base_o))); // R4
  AST_ACT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    act_wr |=> active_o == $past(wdata_i[0])); // R8
  AST_BASE_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> (base_o[15:8] == $past(wdata_i) && $stable(base_o[7:0]))); // R9

endmodule

// File: rtl/cfgp_read_mux.sv
module cfgp_read_mux
  import cfgp_pkg::*;
#(
  parameter int          NUM_DEV  = 4,
  parameter logic [15:0] CHIP_ID  = 16'hA5C3,
  parameter logic [3:0]  CHIP_REV = 4'h6
) (
  input  logic                 rd_idx_i,
  input  logic                 rd_data_i,
  input  logic                 open_i,
  input  logic [7:0]           index_i,
  input  logic [7:0]           ldn_i,
  input  logic [NUM_DEV-1:0]   bank_hit_i,
  input  logic [NUM_DEV*8-1:0] bank_rdata_i,
  output logic [7:0]           rdata_o
);

  logic [7:0] bank_sel_data;

  always_comb begin
    bank_sel_data = 8'h00;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (bank_hit_i[i]) bank_sel_data = bank_sel_data | bank_rdata_i[i*8 +: 8];
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (rd_idx_i) begin
      rdata_o = open_i ? index_i : CLOSED_READ;
    end else if (rd_data_i) begin
      if (!open_i)                rdata_o = CLOSED_READ;
      else if (!is_banked(index_i)) rdata_o = global_read(index_i, ldn_i, CHIP_ID, CHIP_REV);
      else if (|bank_hit_i)       rdata_o = bank_sel_data;
      else                        rdata_o = CLOSED_READ;
    end
  end

endmodule

// File: rtl/cfg_unlock_port.sv
module cfg_unlock_port
  import cfgp_pkg::*;
#(
  parameter logic [15:0] INDEX_ADDR = 16'h002E,
  parameter logic [15:0] DATA_ADDR  = 16'h002F,
  parameter int          NUM_DEV    = 4,
  parameter logic [15:0] CHIP_ID    = 16'hA5C3,
  parameter logic [3:0]  CHIP_REV   = 4'h6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic                  cfg_open,
  output logic [NUM_DEV-1:0]    dev_active,
  output logic [NUM_DEV*16-1:0] dev_base
);

  localparam int BASE_W = 16;

  logic                 hit_idx, hit_data;
  logic                 idx_wr, data_wr, exit_cmd, ldn_wr, bank_wr_any;
  logic [7:0]           index_q, ldn_q;
  logic [NUM_DEV-1:0]   bank_hit;
  logic [NUM_DEV*8-1:0] bank_rdata;

  assign hit_idx     = io_addr == INDEX_ADDR;
  assign hit_data    = io_addr == DATA_ADDR;
  assign idx_wr      = io_wr && hit_idx;
  assign data_wr     = io_wr && hit_data && cfg_open;
  assign exit_cmd    = data_wr && index_q == IDX_EXIT && io_wdata == EXIT_CODE;
  assign ldn_wr      = data_wr && index_q == IDX_LDN;
  assign bank_wr_any = data_wr && is_banked(index_q);

  cfgp_key_seq u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr_i (idx_wr),
    .wbyte_i  (io_wdata),
    .exit_i   (exit_cmd),
    .open_o   (cfg_open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      ldn_q   <= 8'h00;
    end else begin
      if (exit_cmd)                 index_q <= 8'h00;
      else if (idx_wr && cfg_open)  index_q <= io_wdata;
      if (ldn_wr)                   ldn_q   <= io_wdata;
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    assign bank_hit[g] = ldn_q == 8'(g);
    cfgp_dev_bank #(.BASE_W(BASE_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (bank_wr_any && bank_hit[g]),
      .idx_i    (index_q),
      .wdata_i  (io_wdata),
      .active_o (dev_active[g]),
      .base_o   (dev_base[g*BASE_W +: BASE_W]),
      .rdata_o  (bank_rdata[g*8 +: 8])
    );
  end

  cfgp_read_mux #(
    .NUM_DEV  (NUM_DEV),
    .CHIP_ID  (CHIP_ID),
    .CHIP_REV (CHIP_REV)
  ) u_mux (
    .rd_idx_i     (io_rd && hit_idx),
    .rd_data_i    (io_rd && hit_data),
    .open_i       (cfg_open),
    .index_i      (index_q),
    .ldn_i        (ldn_q),
    .bank_hit_i   (bank_hit),
    .bank_rdata_i (bank_rdata),
    .rdata_o      (io_rdata)
  );

  AST_CLOSED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (hit_idx || hit_data) && !cfg_open) |-> io_rdata == 8'hFF); // R4
  AST_CLOSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(dev_active) && $stable(dev_base) && $stable(ldn_q))); // R4
  AST_LDN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ldn_wr |=> $stable(ldn_q)); // R6
  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit)); // R6
  AST_ID_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit_data && cfg_open && index_q == IDX_ID_HI) |-> io_rdata == CHIP_ID[15:8]); // R7

endmodule

// File: tb/cfg_unlock_port_bench.sv
module cfg_unlock_port_bench;

  localparam logic [15:0] IA = 16'h002E;
  localparam logic [15:0] DA = 16'h002F;
  localparam int          ND = 4;
  localparam logic [15:0] ID = 16'hA5C3;
  localparam logic [3:0]  RV = 4'h6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   io_addr = '0;
  logic          io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]    io_wdata = '0;
  logic [7:0]    io_rdata;
  logic          cfg_open;
  logic [ND-1:0] dev_active;
  logic [ND*16-1:0] dev_base;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  cfg_unlock_port #(.INDEX_ADDR(IA), .DATA_ADDR(DA), .NUM_DEV(ND),
                    .CHIP_ID(ID), .CHIP_REV(RV)) u_cfg_unlock_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
    .dev_active(dev_active), .dev_base(dev_base));

  // vector: {op, req, addr, wdata, expected}; op 0 = write, 1 = read and compare
  localparam int NV = 32;
  localparam logic [37:0] VEC [NV] = '{
    {2'd1, 4'd4, DA, 8'h00, 8'hFF},   // R4 closed read
    {2'd0, 4'd4, DA, 8'h55, 8'h00},   // R4 closed write ignored
    {2'd0, 4'd2, IA, 8'h87, 8'h00},   // R2 key
    {2'd0, 4'd2, IA, 8'h01, 8'h00},
    {2'd0, 4'd2, IA, 8'h55, 8'h00},
    {2'd0, 4'd2, IA, 8'h55, 8'h00},
    {2'd0, 4'd7, IA, 8'h20, 8'h00},   // R7
    {2'd1, 4'd7, DA, 8'h00, 8'hA5},
    {2'd0, 4'd7, IA, 8'h21, 8'h00},
    {2'd1, 4'd7, DA, 8'h00, 8'hC3},
    {2'd0, 4'd7, IA, 8'h22, 8'h00},
    {2'd1, 4'd7, DA, 8'h00, 8'h06},
    {2'd1, 4'd5, IA, 8'h00, 8'h22},   // R5 index readback
    {2'd0, 4'd6, IA, 8'h07, 8'h00},   // R6
    {2'd0, 4'd6, DA, 8'h01, 8'h00},
    {2'd1, 4'd6, DA, 8'h00, 8'h01},
    {2'd0, 4'd9, IA, 8'h60, 8'h00},   // R9
    {2'd0, 4'd9, DA, 8'h12, 8'h00},
    {2'd0, 4'd9, IA, 8'h61, 8'h00},
    {2'd0, 4'd9, DA, 8'h34, 8'h00},
    {2'd1, 4'd9, DA, 8'h00, 8'h34},
    {2'd0, 4'd9, IA, 8'h60, 8'h00},
    {2'd1, 4'd9, DA, 8'h00, 8'h12},
    {2'd0, 4'd8, IA, 8'h30, 8'h00},   // R8
    {2'd0, 4'd8, DA, 8'hFF, 8'h00},
    {2'd1, 4'd8, DA, 8'h00, 8'h01},
    {2'd0, 4'd6, IA, 8'h07, 8'h00},   // R6 back to bank 0
    {2'd0, 4'd6, DA, 8'h00, 8'h00},
    {2'd0, 4'd6, IA, 8'h30, 8'h00},
    {2'd1, 4'd6, DA, 8'h00, 8'h00},
    {2'd0, 4'd7, IA, 8'h20, 8'h00},   // R7 with bank 0
    {2'd1, 4'd7, DA, 8'h00, 8'hA5}
  };

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    #2 chk({56'b0, io_rdata}, {56'b0, e}, req);
    io_rd = 1'b0;
  endtask

  task automatic wrrd_chk(input logic [15:0] a, input logic [7:0] d, input logic [7:0] e,
                          input string req);
    @(negedge clk);
    io_wr = 1'b1; io_rd = 1'b1; io_addr = a; io_wdata = d;
    #2 chk({56'b0, io_rdata}, {56'b0, e}, req);
    @(posedge clk); #1;
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  task automatic open_chk(input logic e, input string req);
    @(negedge clk);
    chk({63'b0, cfg_open}, {63'b0, e}, req);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    open_chk(1'b0, "R1");
    chk({60'b0, dev_active}, 64'd0, "R1");
    chk(dev_base, 64'd0, "R1");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][37:36] == 2'd0) wr(VEC[i][31:16], VEC[i][15:8]);
      else rd_chk(VEC[i][31:16], VEC[i][7:0], $sformatf("R%0d vec%0d", VEC[i][35:32], i));
    end
    chk({60'b0, dev_active}, 64'h2, "R8 outputs");
    chk(dev_base, 64'h0000_0000_1234_0000, "R9 outputs");

    // R11: device select write and read together return the old number
    wr(IA, 8'h07);
    wrrd_chk(DA, 8'h01, 8'h00, "R11 ldn");
    rd_chk(DA, 8'h01, "R6 ldn new");

    // R10: exit command
    wr(IA, 8'h02);
    wr(DA, 8'h05);
    open_chk(1'b1, "R10 wrong code");
    rd_chk(DA, 8'h00, "R10 idx2 read");
    wrrd_chk(DA, 8'h02, 8'h00, "R11 exit");
    open_chk(1'b0, "R10 closed");
    rd_chk(DA, 8'hFF, "R10 data FF");
    rd_chk(IA, 8'hFF, "R4 index FF");
    wr(DA, 8'h00);
    chk({60'b0, dev_active}, 64'h2, "R4 closed write");

    // R3: breaking byte equal to first key byte
    wr(IA, 8'h87); wr(IA, 8'h01); wr(IA, 8'h87); wr(IA, 8'h01);
    wr(IA, 8'h55); wr(IA, 8'h55);
    open_chk(1'b1, "R3 restart open");
    wr(IA, 8'h02); wr(DA, 8'h02);
    open_chk(1'b0, "R10 closed again");
    wr(IA, 8'h87); wr(IA, 8'h01); wr(IA, 8'h55); wr(IA, 8'h00); wr(IA, 8'h55);
    open_chk(1'b0, "R3 broken key");
    wr(IA, 8'h87); wr(IA, 8'h87); wr(IA, 8'h01); wr(IA, 8'h55); wr(IA, 8'h55);
    open_chk(1'b1, "R3 repeated first");
    rd_chk(IA, 8'h00, "R10 index cleared");

    // R6: device number out of range
    wr(IA, 8'h07); wr(DA, 8'h04);
    wr(IA, 8'h30);
    rd_chk(DA, 8'hFF, "R6 no bank read");
    wr(DA, 8'h00);
    chk({60'b0, dev_active}, 64'h2, "R6 no bank write");
    wr(IA, 8'h22);
    rd_chk(DA, 8'h06, "R7 rev any ldn");

    // R1: reset in the middle of operation
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    open_chk(1'b0, "R1 rereset");
    chk({60'b0, dev_active}, 64'd0, "R1 rereset");
    chk(dev_base, 64'd0, "R1 rereset");
    rd_chk(DA, 8'hFF, "R1 closed read");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule